// File: doc/BRIEF.md
# External Data Memory Access Controller

This controller sits between an 8051-class processor's data-move path and three on-chip RAM regions. It takes single-byte read and write requests and forms a 16-bit target address. In pointer mode the full 16-bit request address is used. In register-indirect mode only the low byte of the request comes from the request, and the high byte comes from a page register. The controller decodes that address to one of three regions and runs a timed access. During the access it holds a one-hot region select, a read or write strobe, the address and the write data. When the access ends it returns the read byte with a one-cycle done pulse.

The length of every access is one base cycle, plus a stretch count taken from the low three bits of a clock-control register, plus a fixed wait count for the region. Addresses outside every region still complete. They use the stretch timing only, select nothing and read as zero. Writes to the control and page registers are accepted at any time. They only shape accesses that start after the write.

Top module: `xdata_access_ctrl`

## Requirements
- R1: Region decode on the 16-bit target address. 0x0000..0x07FF drives mem_sel bit 0, 0x1000..0x11FF drives bit 1, and 0x2000..0x20FF drives bit 2. Exactly that one bit is high for every cycle of the access, and mem_sel is 0 when no access is active.
- R2: An access lasts 1 + stretch + W cycles of strobe. W is 0 for the bit-0 region, 6 for the bit-1 region and 0 for the bit-2 region.
- R3: After reset the stretch value is 1, so the first access to the bit-0 region lasts 2 cycles. After reset busy, done, both strobes and mem_sel are 0.
- R4: A write with ctl_wr loads the stretch value from ctl_wdata[2:0]. Every value from 0 to 7 sets the length as in R2.
- R5: With req_indirect=1 the target address is {page, req_addr[7:0]}. The page is loaded by page_wr from page_wdata, resets to 0x00, and req_addr[15:8] is ignored. With req_indirect=0 the target address is req_addr.
- R6: mem_rd_stb (for reads) or mem_wr_stb (for writes) is high for every cycle of the access and never outside it. mem_addr holds the target address and mem_wdata holds the write byte for the whole access.
- R7: done is high for exactly one cycle, in the cycle right after the last strobe cycle. On a read, rd_data in that cycle equals the mem_rdata value present in the last strobe cycle.
- R8: For an address in no region, no mem_sel bit is raised, the access lasts 1 + stretch cycles, and a read returns rd_data = 0x00.
- R9: busy is high for exactly the strobe cycles. A request held high during busy is not taken. It is accepted on the first clock edge at which busy is low.
- R10: A stretch or page write made during an access leaves that access's length and address unchanged, and it applies to the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request, held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = 8-bit register-indirect address, 0 = 16-bit pointer |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Access in progress; requests are not taken |
| ctl_wr | input | 1 | Load the stretch field |
| ctl_wdata | input | 8 | Clock-control byte; bits 2:0 are the stretch value |
| page_wr | input | 1 | Load the page register |
| page_wdata | input | 8 | New page (upper address byte) |
| mem_sel | output | 3 | One-hot region select |
| mem_rd_stb | output | 1 | Read strobe |
| mem_wr_stb | output | 1 | Write strobe |
| mem_addr | output | 16 | Target address during the access |
| mem_wdata | output | 8 | Write byte during the access |
| mem_rdata | input | 8 | Byte returned by the selected RAM |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read result, valid with done |

## Verification
A request is taken at the first rising edge where req_valid is high and busy is low. The strobes, select, address and busy rise after that same edge and stay up for 1 + stretch + W cycles. done and rd_data appear one cycle after the last strobe cycle. The bench drives inputs and samples outputs on falling edges. It counts strobe cycles from the first falling edge after acceptance until the strobes drop, and then reads done and rd_data at that same falling edge. It sweeps every stretch value, both address modes, both directions, and the edge addresses of each region and of the gaps between them. It compares the result with a length and decode computed from R1, R2 and R8.

// File: rtl/xdata_pkg.sv
// Package xdata_pkg
// Shared widths and the region table of the external data access controller.
// Assumes regions do not overlap and each ends below the top of the address space.
package xdata_pkg;
    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 8;
    localparam int STRETCH_W   = 3;
    localparam int WAIT_W      = 3;
    localparam int NUM_REGIONS = 3;
    localparam int MAX_WAIT    = 6;
    localparam int CNT_W       = $clog2((2 ** STRETCH_W) + MAX_WAIT + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   size;
        logic [WAIT_W-1:0] waits;
    } region_t;

    // Region table: index equals the select bit driven for that region.
    function automatic region_t region_cfg(input int idx);
        region_t r;
        case (idx)
            0:       r = '{base: 16'h0000, size: 17'h00800, waits: 3'd0};
            1:       r = '{base: 16'h1000, size: 17'h00200, waits: 3'd6};
            default: r = '{base: 16'h2000, size: 17'h00100, waits: 3'd0};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/xdata_region_decode.sv
// Module xdata_region_decode
// Combinational decode of a target address into a one-hot region hit vector
// and the fixed wait count of the hit region. Assumes non-overlapping regions.
module xdata_region_decode
    import xdata_pkg::*;
#(
    parameter int N_REG = NUM_REGIONS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REG-1:0]  hit,
    output logic [WAIT_W-1:0] waits
);
    // One range comparator per region.
    for (genvar g = 0; g < N_REG; g++) begin : g_cmp
        localparam region_t CFG = region_cfg(g);
        logic [ADDR_W:0] a_ext;
        assign a_ext  = {1'b0, addr};
        assign hit[g] = (a_ext >= {1'b0, CFG.base}) &&
                        (a_ext <  ({1'b0, CFG.base} + CFG.size));
    end

    // Select the wait count of whichever region hit (zero when none).
    always_comb begin
        waits = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (hit[i]) waits = waits | region_cfg(i).waits;
        end
    end
endmodule

// File: rtl/xdata_wait_timer.sv
// Module xdata_wait_timer
// Down-counter that keeps an access active for (load + 1) cycles after start.
// Assumes start is only raised while not active.
module xdata_wait_timer
    import xdata_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             active,
    output logic             last
);
    localparam int MAX_LOAD = (2 ** STRETCH_W) - 1 + MAX_WAIT;

    logic [CNT_W-1:0] cnt;

    // Load on start, then count down to zero and drop active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= load;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign last = active && (cnt == '0);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= CNT_W'(MAX_LOAD)));

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);

    // R2
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> (active && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/xdata_access_ctrl.sv
// Module xdata_access_ctrl
// External data space access controller: forms the target address (pointer or
// page + indirect byte), decodes it, times the access as 1 + stretch + region
// waits, drives select and strobes, and returns read data with a done pulse.
// Assumes the requester holds req_valid until a clock edge with busy low.
module xdata_access_ctrl
    import xdata_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_indirect,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   busy,
    input  logic                   ctl_wr,
    input  logic [DATA_W-1:0]      ctl_wdata,
    input  logic                   page_wr,
    input  logic [DATA_W-1:0]      page_wdata,
    output logic [NUM_REGIONS-1:0] mem_sel,
    output logic                   mem_rd_stb,
    output logic                   mem_wr_stb,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   done,
    output logic [DATA_W-1:0]      rd_data
);
    localparam int PAGE_W = ADDR_W - 8;
    localparam logic [STRETCH_W-1:0] STRETCH_RST = STRETCH_W'(1);

    logic [STRETCH_W-1:0]   stretch_q;
    logic [PAGE_W-1:0]      page_q;
    logic [ADDR_W-1:0]      eff_addr;
    logic [NUM_REGIONS-1:0] hit;
    logic [WAIT_W-1:0]      waits;
    logic [CNT_W-1:0]       load_cnt;
    logic                   accept;
    logic                   active;
    logic                   last;
    logic [ADDR_W-1:0]      addr_q;
    logic [DATA_W-1:0]      wdata_q;
    logic [NUM_REGIONS-1:0] sel_q;
    logic                   wr_q;
    logic                   done_q;
    logic [DATA_W-1:0]      rdata_q;

    // Control registers: stretch field and page, written at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stretch_q <= STRETCH_RST;
            page_q    <= '0;
        end else begin
            if (ctl_wr)  stretch_q <= ctl_wdata[STRETCH_W-1:0];
            if (page_wr) page_q    <= page_wdata[PAGE_W-1:0];
        end
    end

    // Target address: page supplies the upper byte in indirect mode.
    assign eff_addr = req_indirect ? {page_q, req_addr[7:0]} : req_addr;

    xdata_region_decode #(.N_REG(NUM_REGIONS)) u_decode (
        .addr  (eff_addr),
        .hit   (hit),
        .waits (waits)
    );

    assign accept   = req_valid && !active;
    assign load_cnt = CNT_W'(stretch_q) + CNT_W'(waits);

    xdata_wait_timer u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .load   (load_cnt),
        .active (active),
        .last   (last)
    );

    // Capture the request so the bus stays stable for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            sel_q   <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= eff_addr;
            wdata_q <= req_wdata;
            sel_q   <= hit;
            wr_q    <= req_write;
        end
    end

    // Completion: pulse done after the last strobe cycle and register read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= last;
            if (last) rdata_q <= (!wr_q && (sel_q != '0)) ? mem_rdata : '0;
        end
    end

    assign busy       = active;
    assign mem_sel    = active ? sel_q : '0;
    assign mem_rd_stb = active && !wr_q;
    assign mem_wr_stb = active &&  wr_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
    assign done       = done_q;
    assign rd_data    = rdata_q;

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_sel));

    // R6
    bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(last)) |-> ($stable(mem_addr) && $stable(mem_sel)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && mem_rd_stb && mem_sel == '0) |=> (rd_data == '0));

    // R10
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last && ctl_wr) |=> busy);
endmodule

// File: tb/xdata_access_ctrl_tb.sv
// Bench xdata_access_ctrl_tb_top
// Sweeps stretch values, address modes, directions and region edge addresses,
// and compares access length, select, address and read data to values
// computed from the requirements.
module xdata_access_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_indirect = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy;
    logic        ctl_wr = 1'b0, page_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0, page_wdata = '0;
    logic [2:0]  mem_sel;
    logic        mem_rd_stb, mem_wr_stb;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        done;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

    xdata_access_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_indirect(req_indirect), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .page_wr(page_wr),
        .page_wdata(page_wdata), .mem_sel(mem_sel), .mem_rd_stb(mem_rd_stb),
        .mem_wr_stb(mem_wr_stb), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_sel(input logic [15:0] a);
        if (a <= 16'h07FF)                    return 3'b001;
        if (a >= 16'h1000 && a <= 16'h11FF)   return 3'b010;
        if (a >= 16'h2000 && a <= 16'h20FF)   return 3'b100;
        return 3'b000;
    endfunction

    function automatic int exp_wait(input logic [15:0] a);
        return (exp_sel(a) == 3'b010) ? 6 : 0;
    endfunction

    task automatic set_stretch(input int s);
        ctl_wdata = 8'(s) | 8'hF8;
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic set_page(input logic [7:0] p);
        page_wdata = p;
        page_wr = 1'b1;
        @(negedge clk);
        page_wr = 1'b0;
    endtask

    // Runs one access from idle at a falling edge; returns strobe length.
    task automatic run_access(input bit wr, input bit ind, input logic [15:0] target,
                              input logic [7:0] wd, input int stretch);
        int len = 0;
        bit sel_ok = 1'b1, addr_ok = 1'b1, stb_ok = 1'b1, busy_ok = 1'b1;
        logic [2:0] es = exp_sel(target);
        int elen = 1 + stretch + exp_wait(target);
        if (ind) begin
            set_page(target[15:8]);
            req_addr = {~target[15:8], target[7:0]};
        end else begin
            req_addr = target;
        end
        req_write = wr; req_indirect = ind; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (mem_rd_stb || mem_wr_stb) begin
            len++;
            if (mem_sel != es) sel_ok = 1'b0;
            if (mem_addr != target) addr_ok = 1'b0;
            if (wr ? (!mem_wr_stb || mem_rd_stb || mem_wdata != wd) : mem_wr_stb) stb_ok = 1'b0;
            if (!busy || done) busy_ok = 1'b0;
            if (len > 40) break;
            @(negedge clk);
        end
        // R2 R4 R8: strobe length
        chk(len == elen, (es == 0) ? "R8 length" : "R2 length", len, elen);
        // R1 R5: select and address
        chk(sel_ok, ind ? "R5 select" : "R1 select", mem_sel, es);
        chk(addr_ok, "R5 address", mem_addr, target);
        // R6 R9
        chk(stb_ok, "R6 strobe/wdata", mem_wdata, wd);
        chk(busy_ok && !busy && mem_sel == 0, "R9 busy window", busy, 0);
        // R7 done one cycle after last strobe
        chk(done, "R7 done", done, 1);
        if (!wr) begin
            logic [7:0] er = (es == 0) ? 8'h00 : (target[7:0] ^ 8'h5A);
            chk(rd_data == er, (es == 0) ? "R8 read zero" : "R7 read data", rd_data, er);
        end
        @(negedge clk);
        chk(!done, "R7 done width", done, 0);
    endtask

    initial begin
        logic [15:0] addrs [11] = '{16'h0000, 16'h07FF, 16'h0800, 16'h0FFF, 16'h1000,
                                    16'h11FF, 16'h1200, 16'h2000, 16'h20FF, 16'h2100, 16'hFFFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        chk(!busy && !done && !mem_rd_stb && !mem_wr_stb && mem_sel == 0, "R3 reset outputs", busy, 0);
        // R3: default stretch is 1
        run_access(1'b0, 1'b0, 16'h0123, 8'h00, 1);
        // R5: page resets to 0
        req_addr = 16'hFF45; req_indirect = 1'b1; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_addr == 16'h0045, "R5 page reset", mem_addr, 16'h0045);
        wait (done); @(negedge clk);

        // R4: sweep of all stretch values over modes, directions, edge addresses
        for (int s = 0; s < 8; s++) begin
            set_stretch(s);
            for (int a = 0; a < 11; a++) begin
                for (int m = 0; m < 4; m++) begin
                    run_access(m[0], m[1], addrs[a], 8'(a * 17 + m + s), s);
                end
            end
        end

        // R9: request held while busy is not taken until idle
        begin
            int len1 = 0, len2 = 0;
            bit held_ok = 1'b1;
            set_stretch(2);
            req_indirect = 1'b0; req_write = 1'b0; req_addr = 16'h0010; req_valid = 1'b1;
            @(negedge clk);
            req_addr = 16'h1010;
            while (busy) begin
                len1++;
                if (mem_addr != 16'h0010 || mem_sel != 3'b001) held_ok = 1'b0;
                if (len1 > 40) break;
                @(negedge clk);
            end
            chk(held_ok && len1 == 3, "R9 held request not taken", len1, 3);
            // done cycle: edge at its end accepts the held request
            chk(done, "R9 done before second", done, 1);
            @(negedge clk);
            req_valid = 1'b0;
            while (busy) begin
                len2++;
                if (len2 > 40) break;
                @(negedge clk);
            end
            chk(len2 == 9, "R9 second access after idle", len2, 9);
            @(negedge clk);
        end

        // R10: mid-access stretch and page writes only affect the next access
        begin
            int len = 0;
            set_page(8'h10);
            set_stretch(2);
            req_indirect = 1'b1; req_write = 1'b0; req_addr = 16'h0020; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            len = 1;
            ctl_wdata = 8'h07; ctl_wr = 1'b1; page_wdata = 8'h20; page_wr = 1'b1;
            @(negedge clk);
            ctl_wr = 1'b0; page_wr = 1'b0;
            while (busy) begin
                len++;
                if (mem_addr != 16'h1020) len = 100;
                if (len > 40) break;
                @(negedge clk);
            end
            chk(len == 9, "R10 length unchanged", len, 9);
            @(negedge clk);
            req_addr = 16'h0030; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk(mem_addr == 16'h2030, "R10 new page applies", mem_addr, 16'h2030);
            len = 0;
            while (busy) begin
                len++;
                if (len > 40) break;
                @(negedge clk);
            end
            chk(len == 8, "R10 new stretch applies", len, 8);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule